// File: doc/BRIEF.md
# EAN barcode serial bit streamer

This block turns a decoded numeric barcode into the serial module stream that an optical barcode reader would deliver, and plays that stream out one module at a time on a single status bit. A controller loads up to thirteen BCD digits and a length code, then pulses `start`. The block validates the request. It completes the check digit where one is missing or must be recomputed, and picks the odd or even left-hand code set from the leading digit. It writes the complete module sequence into an internal cell store and then presents one module every `MODULE_CYCLES` clock cycles.

The serial bit is the inverse of the current module, placed at bit 3 of the `status` byte. Long codes of 13 or 12 digits and short codes of 8 or 7 digits are supported. The stream is framed by runs of zero modules and closed by an end marker. Once the marker is reached the output drops to 0 and playback stays where it is. A request with a bad length or a non-decimal digit is refused and leaves any playback in progress untouched.

Top module: `ean_bit_streamer`

## Requirements
- R1: After reset `status` and `code_reject` read 0, and `status` stays 0 through any number of module periods because the cell store holds only the end marker at entry 0.
- R2: A `start` whose `load_len` is not one of 7, 8, 12 or 13, or whose first `load_len` digits include a value above 9, raises `code_reject` for exactly the one cycle after the strobe and does not disturb the stream being played. Digit slots at or beyond `load_len` are ignored.
- R3: After an accepted `start`, `status` reads 8'h08 from the next cycle until `MODULE_CYCLES` cycles have passed since the strobe edge.
- R4: The stream is `PAD_MODULES` zeros, guard 1,0,1, the left digits, centre guard 0,1,0,1,0, the right digits, guard 1,0,1, `PAD_MODULES` zeros, then the end marker. Module k appears on bit 3 inverted, from (k+1)·`MODULE_CYCLES` cycles after the strobe edge for one period.
- R5: Digit i sits at `load_digits[4i+3:4i]`, with digit 0 leftmost. A long code uses digit 0 only to choose code sets for digits 1..6 and sends digits 7..12 with right codes. Each code is 7 modules, leftmost first. Set A: 0=0001101, 1=0011001, 2=0010011, 3=0111101, 4=0100011, 5=0110001, 6=0101111, 7=0111011, 8=0110111, 9=0001011. A right code is the bitwise complement of the set A code, and a set B code is the right code read backwards. For leading digits 0 to 9 the set B choice for positions 1..6, position 1 first, is: 000000, 001011, 001101, 001110, 010011, 011001, 011100, 010101, 010110, 011010.
- R6: With 12 digits the block appends a check digit equal to (10 − (Σ digit_i·w_i mod 10)) mod 10, with w = 1 for even i and 3 for odd i over digits 0..11. With 13 digits the loaded digit 12 is sent unchanged.
- R7: A short code sends digits 0..3 in set A, then digits 4..6 and a check digit as right codes. The check digit is always recomputed as (10 − (Σ digit_i·w_i mod 10)) mod 10 with w = 3 for even i and 1 for odd i over digits 0..6, so a loaded eighth digit has no effect.
- R8: When playback reaches the end marker, bit 3 goes to 0 and stays 0 in every later period until the next accepted `start`.
- R9: All bits of `status` other than bit 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per CPU cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_digits | input | 52 | Thirteen BCD digits, digit i in bits 4i+3:4i |
| load_len | input | 4 | Number of valid digits |
| start | input | 1 | One-cycle request to encode and play |
| status | output | 8 | Read byte; bit 3 carries the inverted module |
| code_reject | output | 1 | One-cycle pulse after a refused request |

## Verification
The assertions watch the player and builder on every cycle. They check that the pointer and output hold between module ticks, and that a restart forces the output high. They also check that the end marker freezes both the pointer and the output, that the marker lands at the address its format implies, and that every generated check digit is decimal. The exact module patterns can only be shown by the bench scenarios, which compare every played module against an independently built stream. These cover the parity choice per leading digit, the check digit completion for 12 and 8/7-digit inputs, a refused request arriving in the middle of playback, and the end marker holding.

// File: rtl/ean_stream_pkg.sv
package ean_stream_pkg;

    localparam int DIG_MAX  = 13;
    localparam int DIG_BITS = 4 * DIG_MAX;

    typedef enum logic [3:0] {
        SEG_IDLE,
        SEG_LEAD,
        SEG_LGRD,
        SEG_LEFT,
        SEG_CGRD,
        SEG_RIGHT,
        SEG_RGRD,
        SEG_TAIL,
        SEG_MARK
    } seg_e;

    typedef struct packed {
        logic mark;
        logic bit_v;
    } cell_t;

    // set A left code, leftmost module in bit 6
    function automatic logic [6:0] code_set_a(input logic [3:0] d);
        case (d)
            4'd0:    return 7'b0001101;
            4'd1:    return 7'b0011001;
            4'd2:    return 7'b0010011;
            4'd3:    return 7'b0111101;
            4'd4:    return 7'b0100011;
            4'd5:    return 7'b0110001;
            4'd6:    return 7'b0101111;
            4'd7:    return 7'b0111011;
            4'd8:    return 7'b0110111;
            default: return 7'b0001011;
        endcase
    endfunction

    function automatic logic [6:0] code_right(input logic [3:0] d);
        return ~code_set_a(d);
    endfunction

    function automatic logic [6:0] code_set_b(input logic [3:0] d);
        logic [6:0] r;
        logic [6:0] o;
        r = code_right(d);
        for (int i = 0; i < 7; i++) o[i] = r[6-i];
        return o;
    endfunction

    // set B selection for left positions 1..6, position 1 in bit 5
    function automatic logic [5:0] set_b_mask(input logic [3:0] d);
        case (d)
            4'd0:    return 6'b000000;
            4'd1:    return 6'b001011;
            4'd2:    return 6'b001101;
            4'd3:    return 6'b001110;
            4'd4:    return 6'b010011;
            4'd5:    return 6'b011001;
            4'd6:    return 6'b011100;
            4'd7:    return 6'b010101;
            4'd8:    return 6'b010110;
            default: return 6'b011010;
        endcase
    endfunction

endpackage

// File: rtl/ean_digit_check.sv
module ean_digit_check
    import ean_stream_pkg::*;
(
    input  logic [DIG_BITS-1:0] raw_digits,
    input  logic [3:0]          raw_len,
    output logic                code_ok,
    output logic                long_fmt,
    output logic [DIG_BITS-1:0] norm_digits,
    output logic [3:0]          check_digit
);

    logic       len_ok;
    logic       dec_ok;
    logic [9:0] wsum;

    always_comb begin
        len_ok = (raw_len == 4'd7) || (raw_len == 4'd8) ||
                 (raw_len == 4'd12) || (raw_len == 4'd13);
        dec_ok = 1'b1;
        for (int i = 0; i < DIG_MAX; i++) begin
            if ((4'(i) < raw_len) && (raw_digits[4*i +: 4] > 4'd9)) dec_ok = 1'b0;
        end
        long_fmt = (raw_len >= 4'd12);

        wsum = '0;
        if (long_fmt) begin
            for (int i = 0; i < 12; i++)
                wsum = wsum + 10'(raw_digits[4*i +: 4]) * (((i % 2) == 1) ? 10'd3 : 10'd1);
        end else begin
            for (int i = 0; i < 7; i++)
                wsum = wsum + 10'(raw_digits[4*i +: 4]) * (((i % 2) == 0) ? 10'd3 : 10'd1);
        end
        check_digit = 4'((10'd10 - (wsum % 10'd10)) % 10'd10);

        norm_digits = raw_digits;
        if (long_fmt && (raw_len == 4'd12)) norm_digits[48 +: 4] = check_digit;
        if (!long_fmt)                      norm_digits[28 +: 4] = check_digit;

        code_ok = len_ok && dec_ok;
    end

endmodule

// File: rtl/ean_stream_builder.sv
module ean_stream_builder
    import ean_stream_pkg::*;
#(
    parameter int PAD_MODULES = 32,
    parameter int AW          = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [DIG_BITS-1:0] load_digits,
    input  logic                load_long,
    output logic                wr_en,
    output logic [AW-1:0]       wr_addr,
    output cell_t               wr_cell
);

    localparam int PW        = 8;
    localparam int SHORT_END = 2 * PAD_MODULES + 67;
    localparam int LONG_END  = 2 * PAD_MODULES + 95;

    typedef struct packed {
        seg_e                seg;
        logic [PW-1:0]       cnt;
        logic [2:0]          sub;
        logic [3:0]          dig;
        logic [AW-1:0]       addr;
        logic [DIG_BITS-1:0] digits;
        logic                long_fmt;
        logic [5:0]          parity;
    } bld_t;

    bld_t cur_q, nxt_d;
    logic [3:0] sel_d;
    logic [6:0] code_d;
    logic [2:0] pidx_d;

    always_comb begin
        nxt_d   = cur_q;
        wr_en   = 1'b0;
        wr_cell = '0;
        sel_d   = cur_q.digits[4*cur_q.dig +: 4];
        pidx_d  = 3'(4'd6 - cur_q.dig);
        code_d  = code_set_a(sel_d);

        case (cur_q.seg)
            SEG_LEAD, SEG_TAIL: begin
                wr_en = 1'b1;
                if (cur_q.cnt == PW'(PAD_MODULES - 1)) begin
                    nxt_d.cnt = '0;
                    nxt_d.seg = (cur_q.seg == SEG_LEAD) ? SEG_LGRD : SEG_MARK;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            SEG_LGRD, SEG_RGRD: begin
                wr_en         = 1'b1;
                wr_cell.bit_v = (cur_q.cnt != PW'(1));
                if (cur_q.cnt == PW'(2)) begin
                    nxt_d.cnt = '0;
                    nxt_d.sub = '0;
                    if (cur_q.seg == SEG_LGRD) begin
                        nxt_d.seg = SEG_LEFT;
                        nxt_d.dig = cur_q.long_fmt ? 4'd1 : 4'd0;
                    end else begin
                        nxt_d.seg = SEG_TAIL;
                    end
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            SEG_LEFT: begin
                wr_en = 1'b1;
                if (cur_q.long_fmt && cur_q.parity[pidx_d]) code_d = code_set_b(sel_d);
                wr_cell.bit_v = code_d[3'(3'd6 - cur_q.sub)];
                if (cur_q.sub == 3'd6) begin
                    nxt_d.sub = '0;
                    if (cur_q.dig == (cur_q.long_fmt ? 4'd6 : 4'd3)) begin
                        nxt_d.seg = SEG_CGRD;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.dig = cur_q.dig + 1'b1;
                    end
                end else begin
                    nxt_d.sub = cur_q.sub + 1'b1;
                end
            end
            SEG_CGRD: begin
                wr_en         = 1'b1;
                wr_cell.bit_v = cur_q.cnt[0];
                if (cur_q.cnt == PW'(4)) begin
                    nxt_d.seg = SEG_RIGHT;
                    nxt_d.cnt = '0;
                    nxt_d.sub = '0;
                    nxt_d.dig = cur_q.long_fmt ? 4'd7 : 4'd4;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            SEG_RIGHT: begin
                wr_en         = 1'b1;
                code_d        = code_right(sel_d);
                wr_cell.bit_v = code_d[3'(3'd6 - cur_q.sub)];
                if (cur_q.sub == 3'd6) begin
                    nxt_d.sub = '0;
                    if (cur_q.dig == (cur_q.long_fmt ? 4'd12 : 4'd7)) begin
                        nxt_d.seg = SEG_RGRD;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.dig = cur_q.dig + 1'b1;
                    end
                end else begin
                    nxt_d.sub = cur_q.sub + 1'b1;
                end
            end
            SEG_MARK: begin
                wr_en        = 1'b1;
                wr_cell.mark = 1'b1;
                nxt_d.seg    = SEG_IDLE;
            end
            default: ;
        endcase

        if (wr_en) nxt_d.addr = cur_q.addr + 1'b1;

        if (load) begin
            nxt_d.seg      = SEG_LEAD;
            nxt_d.cnt      = '0;
            nxt_d.sub      = '0;
            nxt_d.dig      = '0;
            nxt_d.addr     = '0;
            nxt_d.digits   = load_digits;
            nxt_d.long_fmt = load_long;
            nxt_d.parity   = set_b_mask(load_digits[3:0]);
        end
    end

    assign wr_addr = cur_q.addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            cur_q.seg <= SEG_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R4: the end marker lands right after the full frame of its format
    assert_marker_position_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.seg == SEG_MARK) |->
            (cur_q.addr == (cur_q.long_fmt ? AW'(LONG_END) : AW'(SHORT_END))));

endmodule

// File: rtl/ean_cell_store.sv
module ean_cell_store
    import ean_stream_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  cell_t         wr_cell,
    input  logic [AW-1:0] rd_addr,
    output cell_t         rd_cell
);

    cell_t mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '{mark: 1'b1, bit_v: 1'b0};
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_cell;
        end
    end

    assign rd_cell = mem_q[rd_addr];

endmodule

// File: rtl/ean_module_player.sv
module ean_module_player
    import ean_stream_pkg::*;
#(
    parameter int MODULE_CYCLES = 1000,
    parameter int AW            = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  cell_t         rd_cell,
    output logic [AW-1:0] rd_addr,
    output logic          serial_out
);

    localparam int            CW   = $clog2(MODULE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(MODULE_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] ptr;
        logic          out;
    } ply_t;

    ply_t cur_q, nxt_d;
    logic tick;

    always_comb begin
        nxt_d = cur_q;
        tick  = (cur_q.cnt == LAST);
        if (tick) begin
            nxt_d.cnt = '0;
            if (rd_cell.mark) begin
                nxt_d.out = 1'b0;
            end else begin
                nxt_d.out = ~rd_cell.bit_v;
                nxt_d.ptr = cur_q.ptr + 1'b1;
            end
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
        if (restart) begin
            nxt_d.cnt = '0;
            nxt_d.ptr = '0;
            nxt_d.out = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rd_addr    = cur_q.ptr;
    assign serial_out = cur_q.out;

    assert_restart_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> serial_out);

    assert_marker_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rd_cell.mark && !restart) |=> (!serial_out && $stable(cur_q.ptr)));

    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> ($stable(cur_q.ptr) && $stable(serial_out)));

endmodule

// File: rtl/ean_bit_streamer.sv
module ean_bit_streamer
    import ean_stream_pkg::*;
#(
    parameter int MODULE_CYCLES = 1000,
    parameter int PAD_MODULES   = 32,
    parameter int DEPTH         = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIG_BITS-1:0] load_digits,
    input  logic [3:0]          load_len,
    input  logic                start,
    output logic [7:0]          status,
    output logic                code_reject
);

    localparam int AW = $clog2(DEPTH);

    logic                code_ok;
    logic                long_fmt;
    logic [DIG_BITS-1:0] norm_digits;
    logic [3:0]          check_digit;
    logic                accept;
    logic                wr_en;
    logic [AW-1:0]       wr_addr;
    cell_t               wr_cell;
    logic [AW-1:0]       rd_addr;
    cell_t               rd_cell;
    logic                serial_out;
    logic                reject_d, reject_q;

    ean_digit_check u_check (
        .raw_digits  (load_digits),
        .raw_len     (load_len),
        .code_ok     (code_ok),
        .long_fmt    (long_fmt),
        .norm_digits (norm_digits),
        .check_digit (check_digit)
    );

    assign accept   = start && code_ok;
    assign reject_d = start && !code_ok;

    ean_stream_builder #(.PAD_MODULES(PAD_MODULES), .AW(AW)) u_build (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .load_digits (norm_digits),
        .load_long   (long_fmt),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_cell     (wr_cell)
    );

    ean_cell_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_cell (wr_cell),
        .rd_addr (rd_addr),
        .rd_cell (rd_cell)
    );

    ean_module_player #(.MODULE_CYCLES(MODULE_CYCLES), .AW(AW)) u_play (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (accept),
        .rd_cell    (rd_cell),
        .rd_addr    (rd_addr),
        .serial_out (serial_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reject_q <= 1'b0;
        else        reject_q <= reject_d;
    end

    assign code_reject = reject_q;
    assign status      = {4'b0000, serial_out, 3'b000};

    assert_check_digit_decimal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (check_digit <= 4'd9));

endmodule

// File: tb/sim_ean_bit_streamer.sv
`timescale 1ns/1ps
module sim_ean_bit_streamer;

    localparam int P   = 5;
    localparam int PAD = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [51:0] load_digits = '0;
    logic [3:0]  load_len = '0;
    logic        start = 1'b0;
    logic [7:0]  status;
    logic        code_reject;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit exp_q[$];

    always #2 clk = ~clk;

    ean_bit_streamer #(.MODULE_CYCLES(P), .PAD_MODULES(PAD), .DEPTH(256)) u0 (
        .clk(clk), .rst_n(rst_n), .load_digits(load_digits), .load_len(load_len),
        .start(start), .status(status), .code_reject(code_reject)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [6:0] ref_a(input int d);
        case (d)
            0: return 7'b0001101; 1: return 7'b0011001; 2: return 7'b0010011;
            3: return 7'b0111101; 4: return 7'b0100011; 5: return 7'b0110001;
            6: return 7'b0101111; 7: return 7'b0111011; 8: return 7'b0110111;
            default: return 7'b0001011;
        endcase
    endfunction

    function automatic logic [6:0] ref_b(input int d);
        logic [6:0] c = ~ref_a(d);
        return {c[0], c[1], c[2], c[3], c[4], c[5], c[6]};
    endfunction

    function automatic logic [5:0] ref_sel(input int d);
        case (d)
            0: return 6'b000000; 1: return 6'b001011; 2: return 6'b001101;
            3: return 6'b001110; 4: return 6'b010011; 5: return 6'b011001;
            6: return 6'b011100; 7: return 6'b010101; 8: return 6'b010110;
            default: return 6'b011010;
        endcase
    endfunction

    task automatic push7(input logic [6:0] c);
        for (int j = 6; j >= 0; j--) exp_q.push_back(c[j]);
    endtask

    task automatic push_pad();
        for (int j = 0; j < PAD; j++) exp_q.push_back(1'b0);
    endtask

    task automatic build_model(input logic [51:0] dg, input int len);
        int dd[13];
        int s;
        logic [5:0] sel;
        exp_q.delete();
        for (int i = 0; i < 13; i++) dd[i] = int'(dg[4*i +: 4]);
        push_pad();
        exp_q.push_back(1); exp_q.push_back(0); exp_q.push_back(1);
        s = 0;
        if (len >= 12) begin
            if (len == 12) begin
                for (int i = 0; i < 12; i++) s += dd[i] * ((i % 2) ? 3 : 1);
                dd[12] = (10 - s % 10) % 10;
            end
            sel = ref_sel(dd[0]);
            for (int p = 0; p < 6; p++) push7(sel[5-p] ? ref_b(dd[p+1]) : ref_a(dd[p+1]));
            exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(0);
            exp_q.push_back(1); exp_q.push_back(0);
            for (int i = 7; i < 13; i++) push7(~ref_a(dd[i]));
        end else begin
            for (int i = 0; i < 7; i++) s += dd[i] * ((i % 2) ? 1 : 3);
            dd[7] = (10 - s % 10) % 10;
            for (int i = 0; i < 4; i++) push7(ref_a(dd[i]));
            exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(0);
            exp_q.push_back(1); exp_q.push_back(0);
            for (int i = 4; i < 8; i++) push7(~ref_a(dd[i]));
        end
        exp_q.push_back(1); exp_q.push_back(0); exp_q.push_back(1);
        push_pad();
    endtask

    // accepted start, then every module compared; optional refused request at module bad_at
    task automatic play(input logic [51:0] dg, input int len, input int bad_at, input string tag);
        logic [7:0] held;
        build_model(dg, len);
        @(negedge clk);
        load_digits = dg; load_len = 4'(len); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R3 high after start", status, 8'h08);
        chk("R2 no reject on valid", {7'd0, code_reject}, 8'h00);
        repeat (P - 1) @(posedge clk);
        @(negedge clk);
        chk("R3 high to end of first period", status, 8'h08);
        for (int k = 0; k <= exp_q.size(); k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k < exp_q.size()) chk({tag, " module"}, status, exp_q[k] ? 8'h00 : 8'h08);
            else                  chk("R8 marker drops output", status, 8'h00);
            if (k == bad_at) begin
                held = status;
                load_digits = dg; load_len = 4'd9; start = 1'b1;
                @(posedge clk);
                @(negedge clk);
                start = 1'b0;
                chk("R2 reject pulse mid-stream", {7'd0, code_reject}, 8'h01);
                chk("R2 output undisturbed", status, held);
                repeat (P - 2) @(posedge clk);
            end else begin
                repeat (P - 1) @(posedge clk);
            end
        end
        repeat (3 * P) @(posedge clk);
        @(negedge clk);
        chk("R8 marker holds", status, 8'h00);
        chk("R9 upper and lower bits zero", status & 8'hF7, 8'h00);
    endtask

    task automatic refuse(input logic [51:0] dg, input int len, input string tag);
        logic [7:0] held;
        @(negedge clk);
        held = status;
        load_digits = dg; load_len = 4'(len); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk({tag, " reject pulse"}, {7'd0, code_reject}, 8'h01);
        chk({tag, " status kept"}, status, held);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " reject single cycle"}, {7'd0, code_reject}, 8'h00);
    endtask

    function automatic logic [51:0] rand_digits();
        logic [51:0] v;
        for (int i = 0; i < 13; i++) v[4*i +: 4] = 4'($urandom_range(0, 9));
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [51:0] dg;
        int lens[4] = '{7, 8, 12, 13};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset status", status, 8'h00);
        chk("R1 reset reject", {7'd0, code_reject}, 8'h00);
        repeat (4 * P) @(posedge clk);
        @(negedge clk);
        chk("R1 idle output stays low", status, 8'h00);

        // R2: refused requests while idle
        refuse(52'h0, 9, "R2 bad length");
        refuse(52'h0000000A00000, 13, "R2 non-decimal digit");
        refuse(52'h0, 0, "R2 zero length");

        // R5: leading digits 0 and 7 pick different code sets
        play(52'h1098765432100, 13, -1, "R5 lead0");
        play(52'h5432109876547, 13, -1, "R5 lead7");
        // R6: 12 digits get a computed check, 13th slot garbage-free decimal
        play(52'h0210987654321, 12, -1, "R6 computed");
        play(52'h9210987654321, 13, -1, "R6 loaded");
        // R7: 8th digit ignored, check recomputed; R2 slots past length ignored
        play(52'hFFFFF93456789, 8, -1, "R7 eight");
        play(52'hFFFFFF1234567, 7, 40, "R7 seven");

        for (int n = 0; n < 12; n++) begin
            dg = rand_digits();
            play(dg, lens[$urandom_range(0, 3)], (n == 3) ? 70 : -1, "R4 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule